// File: doc/BRIEF.md
# Interleaved Multi-Lane String Matcher

This block scans a byte stream that arrives `W` bytes per clock and finds every occurrence of one fixed search string. An occurrence may start and end at any byte position, so it can cross word boundaries. The string and the lane count are elaboration-time parameters.

The string is split into `W` interleaved substrings. Substring `j` holds the characters at string positions `j`, `j+W`, `j+2W` and so on. Every byte lane has its own small matcher. That matcher follows all `W` substrings over the bytes that pass through its lane, and each cycle it reports which substrings have just completed. This gives `W·W` completion bits per cycle.

A combining stage keeps the previous word's completion bits. For each possible end lane, it checks that every substring completed on the lane, and in the word, that the string's geometry requires. It then registers a per-lane match vector and a single match flag.

Top module: `interleaved_matcher`

## Requirements
- R1: The reset is synchronous and active high. It clears all lane matchers and the word history, and it forces `match_o` and `match_lane_o` low in the cycle after it is sampled. A partial occurrence seen before a reset never completes afterwards.
- R2: Byte lane `k` is `in_data[8k+7:8k]`, and lane 0 comes first in stream order. When a valid word holds the final byte of an occurrence on lane `k`, bit `k` of `match_lane_o` is high in exactly the next cycle. At no other time is it high.
- R3: An occurrence is detected whichever of the `W` lanes its final byte lands on.
- R4: An occurrence whose bytes span two or more consecutive valid words is detected, including the case where its last `W` bytes straddle a word boundary.
- R5: A word with `in_valid` low is not part of the stream. It does not advance any matcher, an occurrence may continue across such idle cycles, and the outputs are low in the cycle after an idle word.
- R6: Occurrences that overlap in the stream are each reported at their own end position.
- R7: `match_o` is high exactly when at least one bit of `match_lane_o` is high.
- R8: A sequence that differs from the search string in any single byte is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 8*W | Input word; lane 0 in the low byte is first in stream order |
| match_o | output | 1 | Registered flag: an occurrence ended in the previous valid word |
| match_lane_o | output | W | Registered vector: the lanes on which an occurrence ended |

## Verification
Several properties are checked on every cycle:
- the outputs are cleared after reset and stay quiet after an idle word;
- the match flag agrees with the lane vector;
- any reported lane carried the string's final character in the previous valid word.

Whether a report is complete and exact needs the bench's byte-serial reference over the whole stream. That covers injection at each lane offset, boundary straddling, idle gaps inside an occurrence, overlapping occurrences, single-byte near misses and a reset in the middle of an occurrence.

// File: rtl/sm_pkg.sv
package sm_pkg;

  // Number of characters in interleaved substring j of a string of length l.
  function automatic int sub_len(input int l, input int w, input int j);
    return (l - j + w - 1) / w;
  endfunction

  // Distance, in bytes, from the last character of substring j to the
  // last character of the whole string.
  function automatic int end_gap(input int l, input int w, input int j);
    int last_idx;
    last_idx = j + (sub_len(l, w, j) - 1) * w;
    return l - 1 - last_idx;
  endfunction

endpackage

// File: rtl/sm_substr_track.sv
// Tracks one interleaved substring over the bytes of one lane.
module sm_substr_track #(
  parameter int                 W       = 4,
  parameter int                 L       = 14,
  parameter int                 J       = 0,
  parameter logic [8*L-1:0]     PATTERN = "tick-tock-tick"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output logic       hit_o
);
  localparam int LEN = sm_pkg::sub_len(L, W, J);

  logic [LEN-1:0] eq;

  for (genvar k = 0; k < LEN; k++) begin : g_cmp
    localparam int         IDX = J + k * W;
    localparam logic [7:0] CH  = PATTERN[8*(L-1-IDX) +: 8];
    assign eq[k] = (byte_i == CH);
  end

  if (LEN == 1) begin : g_single
    assign hit_o = valid_i & eq[0];
  end else begin : g_multi
    logic [LEN-2:0] state_q;
    logic [LEN-1:0] chain;

    assign chain[0] = eq[0];
    for (genvar k = 1; k < LEN; k++) begin : g_chain
      assign chain[k] = state_q[k-1] & eq[k];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        state_q <= '0;
      end else if (valid_i) begin
        state_q <= chain[LEN-2:0];
      end
    end

    assign hit_o = valid_i & chain[LEN-1];
  end

endmodule

// File: rtl/sm_lane_fsm.sv
// One byte lane: follows every interleaved substring on its own bytes.
module sm_lane_fsm #(
  parameter int             W       = 4,
  parameter int             L       = 14,
  parameter logic [8*L-1:0] PATTERN = "tick-tock-tick"
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] hit_o
);

  for (genvar j = 0; j < W; j++) begin : g_sub
    sm_substr_track #(
      .W(W), .L(L), .J(j), .PATTERN(PATTERN)
    ) u_trk (
      .clk    (clk),
      .rst    (rst),
      .valid_i(valid_i),
      .byte_i (byte_i),
      .hit_o  (hit_o[j])
    );
  end

endmodule

// File: rtl/sm_combine.sv
// Joins the per-lane completion vectors into per-lane end matches.
// hits_i bit (lane*W + j) means substring j completed on that lane in this word.
module sm_combine #(
  parameter int W = 4,
  parameter int L = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_i,
  input  logic [W*W-1:0] hits_i,
  output logic           match_o,
  output logic [W-1:0]   lane_o
);
  logic [W*W-1:0] need;
  logic [W-1:0]   end_ok;

  for (genvar e = 0; e < W; e++) begin : g_end
    for (genvar j = 0; j < W; j++) begin : g_sub
      localparam int D = sm_pkg::end_gap(L, W, j);
      localparam int T = e - D;
      if (T >= 0) begin : g_cur
        assign need[e*W+j] = hits_i[T*W+j];
      end else begin : g_prev
        logic h_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            h_q <= 1'b0;
          end else if (valid_i) begin
            h_q <= hits_i[(T+W)*W+j];
          end
        end
        assign need[e*W+j] = h_q;
      end
    end
    assign end_ok[e] = &need[e*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_o  <= '0;
      match_o <= 1'b0;
    end else begin
      lane_o  <= valid_i ? end_ok : '0;
      match_o <= valid_i & (|end_ok);
    end
  end

endmodule

// File: rtl/interleaved_matcher.sv
module interleaved_matcher #(
  parameter int             W       = 4,
  parameter int             L       = 14,
  parameter logic [8*L-1:0] PATTERN = "tick-tock-tick"
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [8*W-1:0] in_data,
  output logic           match_o,
  output logic [W-1:0]   match_lane_o
);
  logic [W*W-1:0] hits;

  for (genvar g = 0; g < W; g++) begin : g_lane
    sm_lane_fsm #(
      .W(W), .L(L), .PATTERN(PATTERN)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .valid_i(in_valid),
      .byte_i (in_data[8*g +: 8]),
      .hit_o  (hits[g*W +: W])
    );
  end

  sm_combine #(
    .W(W), .L(L)
  ) u_comb (
    .clk    (clk),
    .rst    (rst),
    .valid_i(in_valid),
    .hits_i (hits),
    .match_o(match_o),
    .lane_o (match_lane_o)
  );

endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
  parameter int             W       = 4,
  parameter int             L       = 14,
  parameter logic [8*L-1:0] PATTERN = "tick-tock-tick"
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [8*W-1:0] in_data,
  input logic           match_o,
  input logic [W-1:0]   match_lane_o
);
  localparam logic [7:0] LAST_CH = PATTERN[7:0];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!match_o && match_lane_o == '0));  // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !match_o);  // R5

  AST_FLAG_AGREES: assert property (@(posedge clk) disable iff (rst)
    match_o == (|match_lane_o));  // R7

  for (genvar e = 0; e < W; e++) begin : g_lane
    AST_END_BYTE: assert property (@(posedge clk) disable iff (rst)
      match_lane_o[e] |-> ($past(in_valid) && $past(in_data[8*e +: 8]) == LAST_CH));  // R2
  end

endmodule

bind interleaved_matcher sm_checker #(
  .W(W), .L(L), .PATTERN(PATTERN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .match_o     (match_o),
  .match_lane_o(match_lane_o)
);

// File: tb/sim_interleaved_matcher.sv
module sim_interleaved_matcher;
  localparam int             W   = 4;
  localparam int             L   = 14;
  localparam logic [8*L-1:0] PAT = "tick-tock-tick";

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [8*W-1:0] in_data = '0;
  logic           match_o;
  logic [W-1:0]   match_lane_o;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] exp_lane = '0;
  string tag = "R1";
  logic [7:0] txq[$];
  logic [7:0] refq[$];

  always #4 clk = ~clk;

  interleaved_matcher #(.W(W), .L(L), .PATTERN(PAT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .match_o(match_o), .match_lane_o(match_lane_o)
  );

  function automatic logic [7:0] pch(input int i);
    return PAT[8*(L-1-i) +: 8];
  endfunction

  function automatic logic [7:0] rand_byte();
    int r;
    r = $urandom_range(0, 5);
    case (r)
      0: return "t";
      1: return "i";
      2: return "c";
      3: return "k";
      4: return "-";
      default: return "o";
    endcase
  endfunction

  // Byte-serial reference: returns 1 when the last L bytes equal the string.
  function automatic bit ref_push(input logic [7:0] b);
    bit hit;
    refq.push_back(b);
    if (refq.size() > L) void'(refq.pop_front());
    hit = (refq.size() == L);
    for (int i = 0; i < L && hit; i++) if (refq[i] != pch(i)) hit = 0;
    return hit;
  endfunction

  task automatic check_outputs();
    compared++;
    if (match_lane_o !== exp_lane) begin
      mismatched++;
      $display("FAIL %s: match_lane_o got %b expected %b", tag, match_lane_o, exp_lane);
    end
    compared++;
    if (match_o !== (|exp_lane)) begin
      mismatched++;
      $display("FAIL R7 (%s): match_o got %b expected %b", tag, match_o, |exp_lane);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [8*W-1:0] d);
    @(negedge clk);
    check_outputs();
    rst = r;
    in_valid = v;
    in_data = d;
    exp_lane = '0;
    if (r) begin
      refq.delete();
    end else if (v) begin
      for (int k = 0; k < W; k++) exp_lane[k] = ref_push(d[8*k +: 8]);
    end
  endtask

  task automatic idle_word();
    logic [8*W-1:0] d;
    for (int k = 0; k < W; k++) d[8*k +: 8] = rand_byte();
    step(0, 0, d);
  endtask

  task automatic send_queue(input int idle_pct);
    logic [8*W-1:0] d;
    while (txq.size() > 0) begin
      if ($urandom_range(0, 99) < idle_pct) idle_word();
      for (int k = 0; k < W; k++)
        d[8*k +: 8] = (txq.size() > 0) ? txq.pop_front() : rand_byte();
      step(0, 1, d);
    end
  endtask

  task automatic push_pattern();
    for (int i = 0; i < L; i++) txq.push_back(pch(i));
  endtask

  task automatic push_random(input int n);
    for (int i = 0; i < n; i++) txq.push_back(rand_byte());
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: outputs held low while reset is applied
    tag = "R1";
    repeat (3) step(1, 0, '0);
    step(0, 0, '0);

    // R3 and R4: string injected at every lane offset, straddling words
    tag = "R3 R4";
    for (int o = 0; o < W; o++) begin
      push_random(o);
      push_pattern();
      push_random(W + 3);
      send_queue(0);
    end

    // R5: idle words scattered inside occurrences
    tag = "R5";
    for (int o = 0; o < W; o++) begin
      push_random(o + 1);
      push_pattern();
      push_random(W);
      send_queue(50);
    end

    // R6: overlapping occurrences sharing a border
    tag = "R6";
    push_random(1);
    push_pattern();
    for (int i = 4; i < L; i++) txq.push_back(pch(i));
    push_random(W);
    send_queue(0);

    // R8: single-byte near misses at every position
    tag = "R8";
    for (int p = 0; p < L; p++) begin
      push_random(p % W);
      for (int i = 0; i < L; i++) txq.push_back((i == p) ? 8'h23 : pch(i));
      push_random(2);
      send_queue(0);
    end

    // R1: reset in the middle of an occurrence drops the partial state
    tag = "R1";
    push_random(2);
    for (int i = 0; i < L - 4; i++) txq.push_back(pch(i));
    send_queue(0);
    step(1, 0, '0);
    for (int i = L - 4; i < L; i++) txq.push_back(pch(i));
    push_random(W);
    send_queue(0);

    // R2: long random stream with occasional injections and idles
    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      push_random($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) push_pattern();
      send_queue(20);
    end

    step(0, 0, '0);
    step(0, 0, '0);
    finish_run();
  end

endmodule